// File: doc/BRIEF.md
# SIMD Predication and Global Condition Unit

This block governs conditional execution across an array of identical processing nodes that all receive the same operation stream on every cycle. Each node keeps its own stack of condition flags. A conditional region is opened by pushing each node's current condition code. It is flipped to its complementary branch by an invert command and closed by a pop. The only thing that differs from node to node is an enable bit. Operations that arrive while a node is disabled are turned into no-ops for that node, and program flow is left alone.

For control flow that depends on all nodes at once, the block reduces the condition codes across the array. One result is true when every node's condition is true (AND) and the other is true when at least one node's condition is true (OR). A parameter decides whether nodes that are currently disabled take part in the reduction. If they are excluded, a disabled node counts as true for the AND and as false for the OR. The controller selects one of the two reductions and may also AND it with a scalar integer condition. The resulting branch decision is registered.

Commands are encoded on a 2-bit field: 0 = hold, 1 = push, 2 = invert (else), 3 = pop. Every node shares one nesting depth, because every node sees the same commands.

Top module: `simd_cond_unit`

## Requirements
- R1: After reset every bit of node_en is 1, stk_err is 0 and br_taken is 0.
- R2: A push (cmd = 1) below full depth sets each node's enable on the next cycle to its previous enable AND its node_cc bit.
- R3: A pop (cmd = 3) at nonzero depth restores, on the next cycle, the enables that were in force just before the matching push.
- R4: An invert (cmd = 2) at nonzero depth sets each node's enable to the enclosing enable AND the inverse of the condition pushed for the innermost level. A second invert brings back the first branch.
- R5: A push at full depth (DEPTH levels) leaves node_en unchanged and sets stk_err.
- R6: A pop or an invert at depth 0 leaves node_en unchanged and sets stk_err.
- R7: Once stk_err is set it stays at 1 until reset.
- R8: node_issue equals node_en when op_valid is 1 and is all zeros when op_valid is 0, in the same cycle.
- R9: glob_all is the AND and glob_any the OR of node_cc over the array, in the same cycle. With MASK_IDLE = 1, a disabled node counts as 1 for glob_all and 0 for glob_any. With MASK_IDLE = 0, every node counts.
- R10: One cycle after br_req = 1, br_taken equals the selected reduction (br_sel = 0 selects glob_all, br_sel = 1 selects glob_any), ANDed with scalar_cond when br_use_scalar = 1.
- R11: One cycle after br_req = 0, br_taken is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Stack command: 0 hold, 1 push, 2 invert, 3 pop |
| node_cc | input | NODES | Per-node condition code |
| op_valid | input | 1 | An operation is broadcast this cycle |
| node_en | output | NODES | Per-node active condition |
| node_issue | output | NODES | Per-node operation enable (0 means no-op) |
| glob_all | output | 1 | AND reduction of condition codes |
| glob_any | output | 1 | OR reduction of condition codes |
| br_req | input | 1 | Evaluate a global branch this cycle |
| br_sel | input | 1 | 0 selects the AND result, 1 selects the OR result |
| br_use_scalar | input | 1 | Also require scalar_cond |
| scalar_cond | input | 1 | Scalar integer condition |
| br_taken | output | 1 | Registered branch decision |
| stk_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench builds the block with NODES = 4 and DEPTH = 3. At that depth, three pushes reach a full stack, so overflow and the full unwind back to depth 0 can be checked after only a handful of commands. Two instances share the same stimulus, one with MASK_IDLE = 1 and one with MASK_IDLE = 0. Because both see identical stacks, the effect of excluding disabled nodes shows up directly, including the case where every node is disabled.

// File: rtl/simd_cond_pkg.sv
package simd_cond_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_PUSH = 2'd1,
    CMD_ELSE = 2'd2,
    CMD_POP  = 2'd3
  } cond_cmd_e;

  // Branch decision from the two reductions and the scalar qualifier.
  function automatic logic branch_decide(input logic all_r, input logic any_r,
                                         input logic sel_any, input logic use_sc,
                                         input logic sc);
    logic g;
    g = sel_any ? any_r : all_r;
    return g & (use_sc ? sc : 1'b1);
  endfunction

endpackage

// File: rtl/cond_depth_ctrl.sv
module cond_depth_ctrl
  import simd_cond_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cond_cmd_e     cmd,
  output logic [DW-1:0] depth_q,
  output logic          do_push,
  output logic          do_else,
  output logic          do_pop,
  output logic          ovf_evt,
  output logic          unf_evt,
  output logic          err_q
);

  logic full, empty;

  assign full    = (depth_q == DW'(DEPTH));
  assign empty   = (depth_q == '0);
  assign do_push = (cmd == CMD_PUSH) && !full;
  assign do_else = (cmd == CMD_ELSE) && !empty;
  assign do_pop  = (cmd == CMD_POP)  && !empty;
  assign ovf_evt = (cmd == CMD_PUSH) && full;
  assign unf_evt = ((cmd == CMD_POP) || (cmd == CMD_ELSE)) && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (do_push)      depth_q <= depth_q + DW'(1);
      else if (do_pop)  depth_q <= depth_q - DW'(1);
      if (ovf_evt || unf_evt) err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/node_cond_stack.sv
module node_cond_stack #(
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cc,
  input  logic [DW-1:0] depth_q,
  input  logic          do_push,
  input  logic          do_else,
  output logic          en
);

  // act_q[k] is the active flag with k open levels; level 0 is always on.
  logic [DEPTH:0]   act_q;
  // cond_q[k] holds the raw condition of level k+1 (inverted by else).
  logic [DEPTH-1:0] cond_q;
  logic [DW-1:0]    up_idx, cur_idx;

  assign up_idx  = depth_q + DW'(1);
  assign cur_idx = depth_q - DW'(1);
  assign en      = act_q[depth_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '1;
      cond_q <= '0;
    end else if (do_push) begin
      act_q[up_idx]   <= act_q[depth_q] & cc;
      cond_q[depth_q] <= cc;
    end else if (do_else) begin
      act_q[depth_q]  <= act_q[cur_idx] & ~cond_q[cur_idx];
      cond_q[cur_idx] <= ~cond_q[cur_idx];
    end
  end

endmodule

// File: rtl/cond_reduce.sv
module cond_reduce #(
  parameter int NODES     = 8,
  parameter bit MASK_IDLE = 1'b1
) (
  input  logic [NODES-1:0] cc,
  input  logic [NODES-1:0] en,
  output logic             all_r,
  output logic             any_r
);

  function automatic logic red_and(input logic [NODES-1:0] v);
    return &v;
  endfunction

  function automatic logic red_or(input logic [NODES-1:0] v);
    return |v;
  endfunction

  generate
    if (MASK_IDLE) begin : g_masked
      assign all_r = red_and(cc | ~en);
      assign any_r = red_or(cc & en);
    end else begin : g_raw
      logic [NODES-1:0] unused_en;
      assign unused_en = en;
      assign all_r = red_and(cc);
      assign any_r = red_or(cc);
    end
  endgenerate

endmodule

// File: rtl/simd_cond_unit.sv
module simd_cond_unit
  import simd_cond_pkg::*;
#(
  parameter int NODES     = 8,
  parameter int DEPTH     = 8,
  parameter bit MASK_IDLE = 1'b1,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic [NODES-1:0] node_cc,
  input  logic             op_valid,
  output logic [NODES-1:0] node_en,
  output logic [NODES-1:0] node_issue,
  output logic             glob_all,
  output logic             glob_any,
  input  logic             br_req,
  input  logic             br_sel,
  input  logic             br_use_scalar,
  input  logic             scalar_cond,
  output logic             br_taken,
  output logic             stk_err
);

  cond_cmd_e     cmd_e;
  logic [DW-1:0] depth_q;
  logic          do_push, do_else, do_pop;
  logic          ovf_evt, unf_evt;
  logic          br_q;

  assign cmd_e = cond_cmd_e'(cmd);

  cond_depth_ctrl #(.DEPTH(DEPTH)) u_depth (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd_e),
    .depth_q (depth_q),
    .do_push (do_push),
    .do_else (do_else),
    .do_pop  (do_pop),
    .ovf_evt (ovf_evt),
    .unf_evt (unf_evt),
    .err_q   (stk_err)
  );

  generate
    for (genvar n = 0; n < NODES; n++) begin : g_node
      node_cond_stack #(.DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .cc      (node_cc[n]),
        .depth_q (depth_q),
        .do_push (do_push),
        .do_else (do_else),
        .en      (node_en[n])
      );
    end
  endgenerate

  cond_reduce #(.NODES(NODES), .MASK_IDLE(MASK_IDLE)) u_reduce (
    .cc    (node_cc),
    .en    (node_en),
    .all_r (glob_all),
    .any_r (glob_any)
  );

  assign node_issue = node_en & {NODES{op_valid}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) br_q <= 1'b0;
    else        br_q <= br_req & branch_decide(glob_all, glob_any, br_sel,
                                               br_use_scalar, scalar_cond);
  end

  assign br_taken = br_q;

endmodule

// File: rtl/simd_cond_chk.sv
module simd_cond_chk #(
  parameter int NODES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd,
  input logic [NODES-1:0] node_cc,
  input logic [NODES-1:0] node_en,
  input logic             ovf_evt,
  input logic             unf_evt,
  input logic             stk_err,
  input logic             br_req,
  input logic             br_taken
);

  // R2
  push_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd1 && !ovf_evt) |=> node_en == ($past(node_en) & $past(node_cc)));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ($stable(node_en) && stk_err));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> ($stable(node_en) && stk_err));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);

  // R11
  no_req_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_req |=> !br_taken);

endmodule

bind simd_cond_unit simd_cond_chk #(.NODES(NODES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd      (cmd),
  .node_cc  (node_cc),
  .node_en  (node_en),
  .ovf_evt  (ovf_evt),
  .unf_evt  (unf_evt),
  .stk_err  (stk_err),
  .br_req   (br_req),
  .br_taken (br_taken)
);

// File: tb/test_simd_cond_unit.sv
module test_simd_cond_unit;

  localparam int N = 4;
  localparam int D = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cmd = 2'd0;
  logic [N-1:0] node_cc = '0;
  logic         op_valid = 1'b0;
  logic         br_req = 1'b0, br_sel = 1'b0, br_use_scalar = 1'b0, scalar_cond = 1'b0;
  logic [N-1:0] node_en, node_issue, en_raw, issue_raw;
  logic         glob_all, glob_any, all_raw, any_raw;
  logic         br_taken, br_raw, stk_err, err_raw;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  simd_cond_unit #(.NODES(N), .DEPTH(D), .MASK_IDLE(1'b1)) i_simd_cond_unit (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .node_cc(node_cc), .op_valid(op_valid),
    .node_en(node_en), .node_issue(node_issue), .glob_all(glob_all), .glob_any(glob_any),
    .br_req(br_req), .br_sel(br_sel), .br_use_scalar(br_use_scalar),
    .scalar_cond(scalar_cond), .br_taken(br_taken), .stk_err(stk_err)
  );

  simd_cond_unit #(.NODES(N), .DEPTH(D), .MASK_IDLE(1'b0)) i_simd_cond_unit_raw (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .node_cc(node_cc), .op_valid(op_valid),
    .node_en(en_raw), .node_issue(issue_raw), .glob_all(all_raw), .glob_any(any_raw),
    .br_req(br_req), .br_sel(br_sel), .br_use_scalar(br_use_scalar),
    .scalar_cond(scalar_cond), .br_taken(br_raw), .stk_err(err_raw)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one command for one clock, then return at the next falling edge.
  task automatic apply(input logic [1:0] c, input logic [N-1:0] cc);
    cmd = c; node_cc = cc;
    @(negedge clk);
    cmd = 2'd0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd = 2'd0; br_req = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 en", 32'(node_en), 32'hF);
    check("R1 err", 32'(stk_err), 0);
    check("R1 br", 32'(br_taken), 0);
  endtask

  task automatic t_nesting();
    apply(2'd1, 4'b1010);
    check("R2 push1", 32'(node_en), 32'hA);
    op_valid = 1'b1; #1;
    check("R8 issue on", 32'(node_issue), 32'hA);
    op_valid = 1'b0; #1;
    check("R8 issue off", 32'(node_issue), 0);
    apply(2'd1, 4'b0110);
    check("R2 push2", 32'(node_en), 32'h2);
    apply(2'd2, 4'b0000);
    check("R4 else", 32'(node_en), 32'h8);
    apply(2'd2, 4'b0000);
    check("R4 else twice", 32'(node_en), 32'h2);
    apply(2'd3, 4'b0000);
    check("R3 pop inner", 32'(node_en), 32'hA);
    apply(2'd3, 4'b0000);
    check("R3 pop outer", 32'(node_en), 32'hF);
    check("R6 no err", 32'(stk_err), 0);
  endtask

  task automatic t_reduce();
    node_cc = 4'b1111; #1;
    check("R9 all1", 32'({glob_all, glob_any}), 32'h3);
    node_cc = 4'b0100; #1;
    check("R9 mixed", 32'({glob_all, glob_any}), 32'h1);
    apply(2'd1, 4'b0011);
    node_cc = 4'b0011; #1;
    check("R9 masked true", 32'({glob_all, glob_any}), 32'h3);
    check("R9 raw true", 32'({all_raw, any_raw}), 32'h1);
    node_cc = 4'b1100; #1;
    check("R9 masked false", 32'({glob_all, glob_any}), 32'h0);
    check("R9 raw false", 32'({all_raw, any_raw}), 32'h1);
    apply(2'd1, 4'b0000);
    check("R2 all off", 32'(node_en), 0);
    node_cc = 4'b0101; #1;
    check("R9 none enabled", 32'({glob_all, glob_any}), 32'h2);
    check("R9 raw none", 32'({all_raw, any_raw}), 32'h1);
    apply(2'd3, 4'b0000);
    apply(2'd3, 4'b0000);
    check("R3 unwind", 32'(node_en), 32'hF);
  endtask

  task automatic branch(input logic [N-1:0] cc, input logic req, input logic sel,
                        input logic use_sc, input logic sc, input logic exp,
                        input string tag);
    node_cc = cc; br_req = req; br_sel = sel; br_use_scalar = use_sc; scalar_cond = sc;
    @(negedge clk);
    br_req = 1'b0;
    check(tag, 32'(br_taken), 32'(exp));
  endtask

  task automatic t_branch();
    branch(4'b1111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10 all true");
    branch(4'b1110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 all false");
    branch(4'b0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R10 any true");
    branch(4'b0001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R10 scalar blocks");
    branch(4'b0001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R10 scalar passes");
    branch(4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10 any false");
    branch(4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 no request");
  endtask

  task automatic t_overflow();
    apply(2'd1, 4'b1110);
    apply(2'd1, 4'b1100);
    apply(2'd1, 4'b1000);
    check("R2 full", 32'(node_en), 32'h8);
    check("R5 not yet", 32'(stk_err), 0);
    apply(2'd1, 4'b0000);
    check("R5 en kept", 32'(node_en), 32'h8);
    check("R5 err", 32'(stk_err), 1);
    apply(2'd3, 4'b0000);
    check("R3 lvl2", 32'(node_en), 32'hC);
    apply(2'd3, 4'b0000);
    apply(2'd3, 4'b0000);
    check("R3 lvl0", 32'(node_en), 32'hF);
    check("R7 sticky", 32'(stk_err), 1);
  endtask

  task automatic t_underflow();
    do_reset();
    check("R1 err cleared", 32'(stk_err), 0);
    apply(2'd3, 4'b0000);
    check("R6 pop en", 32'(node_en), 32'hF);
    check("R6 pop err", 32'(stk_err), 1);
    do_reset();
    apply(2'd2, 4'b0000);
    check("R6 else en", 32'(node_en), 32'hF);
    check("R6 else err", 32'(stk_err), 1);
    apply(2'd0, 4'b0000);
    check("R7 hold", 32'(stk_err), 1);
  endtask

  initial begin
    t_reset();
    t_nesting();
    t_reduce();
    t_branch();
    t_overflow();
    t_underflow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule